// File: doc/BRIEF.md
# Dual Sample FIFO with Threshold Interrupts

The block holds two independent byte-wide sample queues, channel A and channel B, each with a parameterised depth of 1024 bytes. A host fills them one byte at a time and a sample-rate consumer drains them. On every sample tick each non-empty queue hands its oldest byte to its channel output. An empty queue hands over the midscale value 0x80.

Each queue keeps a two-bit status: a "below half" flag in bit 0 and a "full or empty reached" flag in bit 1. One shared interrupt line is raised when the occupancy crosses exact thresholds in either direction. The host reads both status fields as one 4-bit value and acknowledges them with a read strobe. A control write can flush both queues and also sets the per-queue half-threshold interrupt enables. While both queues stay drained, an idle timer keeps raising empty interrupts, one every 1024 sample ticks.

Top module: `snd_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `statData` is 0, `irq` is low, both sample outputs hold 0x80, and both half-threshold enables are 1.
- R2: Bytes leave each queue in the order they were pushed, across the wrap of the 1024-entry pointers. On a cycle with `tick` high, each non-empty queue pops one byte, and it appears on its sample output after that clock edge.
- R3: On a tick that finds a queue empty, that channel's output becomes 0x80 and the queue state is unchanged. A later push is then the next byte delivered.
- R4: A push into a queue that already holds 1024 bytes is dropped.
- R5: After any push or pop on a queue, its status bit 0 is 1 when the resulting count is 511 or less, and 0 otherwise.
- R6: A push that makes the count exactly 512, or a pop that makes it exactly 511, raises `irq` only when that queue's half enable is 1. Every `ctlWr` loads the enables from `ctlData` bit 0 (A) and bit 1 (B).
- R7: A push that makes the count 1023, or a pop that makes it 0, sets that queue's status bit 1 and raises `irq` whatever the enables are.
- R8: A push and a pop on the same queue in one cycle leave the count unchanged, raise no threshold event, and refresh bit 0 from the count.
- R9: `statData` shows {B.bit1, B.bit0, A.bit1, A.bit0} in bits 3..0. A cycle with `statRd` high clears all status bits and drops `irq` at that edge. Events in the same cycle are still recorded.
- R10: A `ctlWr` with `ctlData` bit 7 set empties both queues, clears status and `irq`, and restarts the idle timer. Pushes and pops in that cycle are discarded.
- R11: On the 1024th consecutive tick at which both queues are found empty, all four status bits are set, `irq` is raised and the idle count restarts. A tick that finds either queue non-empty restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host push strobe |
| wrSel | input | 1 | Target queue of the push: 0 = A, 1 = B |
| wrData | input | 8 | Byte pushed |
| ctlWr | input | 1 | Control write strobe |
| ctlData | input | 8 | Control byte: bit 7 flush, bits 1..0 half enables for B and A |
| statRd | input | 1 | Status read-and-acknowledge strobe |
| statData | output | 4 | Packed status of both queues |
| tick | input | 1 | Sample-period strobe from the consumer |
| sampA | output | 8 | Channel A sample |
| sampB | output | 8 | Channel B sample |
| irq | output | 1 | Shared interrupt |

## Verification
A corrupted pointer or count shows up at the sample outputs on the very next tick that drains the affected queue. It appears either as a byte out of push order or as a 0x80 while data is still held. A count that is off by one moves the threshold events by one push or pop, so `irq` and `statData` change one cycle early or late, at the 511/512 and 0/1023 boundaries. An idle counter that runs at the wrong rate shifts the all-ones status by whole ticks, which becomes visible after 1024 empty ticks.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int NFIFO = 2;
  localparam int FLUSH_BIT = 7;

  typedef struct packed {
    logic [NFIFO-1:0] push;
    logic [NFIFO-1:0] pop;
    logic take;
    logic flush;
    logic ack;
  } sfpStrobe_t;
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrSel,
  input  logic ctlWr,
  input  logic [7:0] ctlData,
  input  logic statRd,
  input  logic tick,
  input  logic [NFIFO-1:0] isFull,
  input  logic [NFIFO-1:0] isEmpty,
  output sfpStrobe_t stb,
  output logic [NFIFO-1:0] halfEn
);
  always_comb begin
    stb.flush = ctlWr & ctlData[FLUSH_BIT];
    stb.take  = tick;
    stb.ack   = statRd;
    for (int i = 0; i < NFIFO; i++) begin
      stb.push[i] = wrEn & (wrSel == 1'(i)) & ~isFull[i] & ~stb.flush;
      stb.pop[i]  = tick & ~isEmpty[i] & ~stb.flush;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) halfEn <= '1;
    else if (ctlWr) halfEn <= ctlData[NFIFO-1:0];
  end
endmodule

// File: rtl/sfp_datapath.sv
module sfp_datapath
  import sfp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic clk,
  input  logic rstN,
  input  sfpStrobe_t stb,
  input  logic [DW-1:0] wrData,
  output logic [NFIFO-1:0][CW-1:0] level,
  output logic [NFIFO-1:0] isFull,
  output logic [NFIFO-1:0] isEmpty,
  output logic [NFIFO-1:0][DW-1:0] samp
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  for (genvar g = 0; g < NFIFO; g++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wPtr, rPtr;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sampR;

    always_ff @(posedge clk) begin
      if (stb.push[g]) mem[wPtr] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN || stb.flush) begin
        wPtr <= '0;
        rPtr <= '0;
        cnt  <= '0;
      end else begin
        if (stb.push[g]) wPtr <= wPtr + 1'b1;
        if (stb.pop[g])  rPtr <= rPtr + 1'b1;
        cnt <= cnt + CW'(stb.push[g]) - CW'(stb.pop[g]);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) sampR <= MID;
      else if (stb.pop[g]) sampR <= mem[rPtr];
      else if (stb.take) sampR <= MID;
    end

    assign level[g]   = cnt;
    assign isFull[g]  = (cnt == CW'(DEPTH));
    assign isEmpty[g] = (cnt == '0);
    assign samp[g]    = sampR;
  end
endmodule

// File: rtl/sfp_flags.sv
module sfp_flags
  import sfp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDLE_TICKS = 1024,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2,
  localparam int IW = $clog2(IDLE_TICKS)
) (
  input  logic clk,
  input  logic rstN,
  input  sfpStrobe_t stb,
  input  logic [NFIFO-1:0][CW-1:0] level,
  input  logic [NFIFO-1:0] halfEn,
  output logic [NFIFO-1:0][1:0] status,
  output logic irq
);
  logic [IW-1:0] idleCnt;
  logic allEmpty, idleFire, raise;
  logic [NFIFO-1:0][1:0] nextSt;
  logic [CW-1:0] afterLvl [NFIFO];

  always_comb begin
    allEmpty = 1'b1;
    for (int i = 0; i < NFIFO; i++)
      if (level[i] != '0) allEmpty = 1'b0;
    idleFire = stb.take & allEmpty & (idleCnt == IW'(IDLE_TICKS - 1));
  end

  always_comb begin
    raise = 1'b0;
    for (int i = 0; i < NFIFO; i++) begin
      afterLvl[i] = level[i] + CW'(stb.push[i]) - CW'(stb.pop[i]);
      nextSt[i] = stb.ack ? 2'b00 : status[i];
      if (stb.push[i] ^ stb.pop[i]) begin
        nextSt[i][0] = (afterLvl[i] < CW'(HALF));
        if (stb.push[i]) begin
          if (afterLvl[i] == CW'(HALF) && halfEn[i]) raise = 1'b1;
          if (afterLvl[i] == CW'(DEPTH - 1)) begin
            nextSt[i][1] = 1'b1;
            raise = 1'b1;
          end
        end else begin
          if (afterLvl[i] == CW'(HALF - 1) && halfEn[i]) raise = 1'b1;
          if (afterLvl[i] == '0) begin
            nextSt[i][1] = 1'b1;
            raise = 1'b1;
          end
        end
      end else if (stb.push[i]) begin
        nextSt[i][0] = (level[i] < CW'(HALF));
      end
    end
    if (idleFire) begin
      nextSt = '1;
      raise = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      status  <= '0;
      irq     <= 1'b0;
      idleCnt <= '0;
    end else begin
      status <= nextSt;
      irq    <= (irq & ~stb.ack) | raise;
      if (stb.take) idleCnt <= (allEmpty && !idleFire) ? idleCnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/snd_fifo_pair.sv
module snd_fifo_pair
  import sfp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDLE_TICKS = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrSel,
  input  logic [7:0] wrData,
  input  logic ctlWr,
  input  logic [7:0] ctlData,
  input  logic statRd,
  output logic [3:0] statData,
  input  logic tick,
  output logic [7:0] sampA,
  output logic [7:0] sampB,
  output logic irq
);
  sfpStrobe_t stb;
  logic [NFIFO-1:0] halfEn, isFull, isEmpty;
  logic [NFIFO-1:0][CW-1:0] level;
  logic [NFIFO-1:0][7:0] samp;
  logic [NFIFO-1:0][1:0] status;

  sfp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .ctlWr(ctlWr),
    .ctlData(ctlData), .statRd(statRd), .tick(tick), .isFull(isFull),
    .isEmpty(isEmpty), .stb(stb), .halfEn(halfEn)
  );

  sfp_datapath #(.DEPTH(DEPTH), .DW(8)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .level(level),
    .isFull(isFull), .isEmpty(isEmpty), .samp(samp)
  );

  sfp_flags #(.DEPTH(DEPTH), .IDLE_TICKS(IDLE_TICKS)) u_flags (
    .clk(clk), .rstN(rstN), .stb(stb), .level(level), .halfEn(halfEn),
    .status(status), .irq(irq)
  );

  assign statData = {status[1], status[0]};
  assign sampA = samp[0];
  assign sampB = samp[1];
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker
  import sfp_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic clk,
  input logic rstN,
  input sfpStrobe_t stb,
  input logic [NFIFO-1:0][CW-1:0] level,
  input logic wrEn,
  input logic wrSel,
  input logic ctlWr,
  input logic statRd,
  input logic tick,
  input logic [3:0] statData,
  input logic [7:0] sampA,
  input logic irq
);
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    level[0] <= CW'(DEPTH) && level[1] <= CW'(DEPTH));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrSel && level[0] == CW'(DEPTH) && !tick && !ctlWr |=> level[0] == CW'(DEPTH));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> level[0] == '0 && level[1] == '0 && statData == 4'h0 && !irq);

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    statRd && !wrEn && !tick && !ctlWr |=> statData == 4'h0 && !irq);

  p_empty_mid_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick && level[0] == '0 |=> sampA == 8'h80);

  p_drain_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop[0] && !stb.push[0] && level[0] == CW'(1) |=> irq && statData[1]);

  p_pushpop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.push[0] && stb.pop[0] |=> $stable(level[0]));
endmodule

bind snd_fifo_pair sfp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .level(level), .wrEn(wrEn),
  .wrSel(wrSel), .ctlWr(ctlWr), .statRd(statRd), .tick(tick),
  .statData(statData), .sampA(sampA), .irq(irq)
);

// File: tb/snd_fifo_pair_bench.sv
`timescale 1ns/1ps
module snd_fifo_pair_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, ctlWr = 1'b0, statRd = 1'b0, tick = 1'b0;
  logic [7:0] wrData = '0, ctlData = '0;
  logic [3:0] statData;
  logic [7:0] sampA, sampB;
  logic irq;

  int nChk = 0, nBad = 0;
  bit done = 0;

  // model state
  logic [7:0] qA[$], qB[$];
  logic [1:0] mSt [2];
  logic [1:0] mEn;
  logic mIrq;
  int mIdle;
  logic [7:0] mSampA, mSampB;

  always #2.5 clk = ~clk;

  snd_fifo_pair u_snd_fifo_pair (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctlWr(ctlWr), .ctlData(ctlData), .statRd(statRd), .statData(statData),
    .tick(tick), .sampA(sampA), .sampB(sampB), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  // One clock: drive inputs at negedge, update model, compare after edge.
  task automatic step(input logic iWr, input logic iSel, input logic [7:0] iData,
                      input logic iCtl, input logic [7:0] iCtlData,
                      input logic iRd, input logic iTick);
    int sz [2];
    bit flush, allEmpty, raise, fire;
    wrEn = iWr; wrSel = iSel; wrData = iData; ctlWr = iCtl; ctlData = iCtlData;
    statRd = iRd; tick = iTick;
    sz[0] = qA.size(); sz[1] = qB.size();
    flush = iCtl && iCtlData[7];
    allEmpty = (sz[0] == 0) && (sz[1] == 0);
    raise = 0;
    fire = iTick && allEmpty && (mIdle == 1023);
    for (int i = 0; i < 2; i++) begin
      bit psh, pp;
      int after;
      logic [1:0] ns;
      psh = iWr && (iSel == 1'(i)) && sz[i] < 1024 && !flush;
      pp  = iTick && sz[i] > 0 && !flush;
      after = sz[i] + int'(psh) - int'(pp);
      ns = iRd ? 2'b00 : mSt[i];
      if (psh != pp) begin
        ns[0] = (after <= 511);
        if (psh && after == 512 && mEn[i]) raise = 1;
        if (psh && after == 1023) begin ns[1] = 1; raise = 1; end
        if (pp && after == 511 && mEn[i]) raise = 1;
        if (pp && after == 0) begin ns[1] = 1; raise = 1; end
      end else if (psh) begin
        ns[0] = (sz[i] <= 511);
      end
      mSt[i] = ns;
      if (i == 0) begin
        if (pp) mSampA = qA.pop_front(); else if (iTick) mSampA = 8'h80;
        if (psh) qA.push_back(iData);
      end else begin
        if (pp) mSampB = qB.pop_front(); else if (iTick) mSampB = 8'h80;
        if (psh) qB.push_back(iData);
      end
    end
    if (fire) begin mSt[0] = 2'b11; mSt[1] = 2'b11; raise = 1; end
    mIrq = (mIrq && !iRd) || raise;
    if (iTick) mIdle = (allEmpty && !fire) ? mIdle + 1 : 0;
    if (iCtl) mEn = iCtlData[1:0];
    if (flush) begin
      qA.delete(); qB.delete();
      mSt[0] = 0; mSt[1] = 0; mIrq = 0; mIdle = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R9 status", 32'(statData), 32'({mSt[1], mSt[0]}));
    chk("R6 irq", 32'(irq), 32'(mIrq));
    chk("R2 sampA", 32'(sampA), 32'(mSampA));
    chk("R2 sampB", 32'(sampB), 32'(mSampB));
  endtask

  task automatic push(input logic sel, input logic [7:0] d);
    step(1'b1, sel, d, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask
  task automatic pop1();
    step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask
  task automatic rdStat();
    step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
  endtask
  task automatic ctl(input logic [7:0] v);
    step(1'b0, 1'b0, 8'h00, 1'b1, v, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int errs;
    mSt[0] = 0; mSt[1] = 0; mEn = 2'b11; mIrq = 0; mIdle = 0;
    mSampA = 8'h80; mSampB = 8'h80;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(statData), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sampA", 32'(sampA), 32'h80);
    chk("R1 sampB", 32'(sampB), 32'h80);

    // R5 R6 half threshold on push
    for (int k = 0; k < 511; k++) push(1'b0, pat(k));
    chk("R5 half set at 511", 32'(statData), 32'h1);
    chk("R6 no irq below 512", 32'(irq), 0);
    push(1'b0, pat(511));
    chk("R6 irq at 512", 32'(irq), 1);
    chk("R5 half clear at 512", 32'(statData), 32'h0);
    rdStat();
    chk("R9 read drops irq", 32'(irq), 0);

    // R7 full flag, R4 drop
    for (int k = 512; k < 1023; k++) push(1'b0, pat(k));
    chk("R7 fe at 1023", 32'(statData), 32'h2);
    chk("R7 irq at 1023", 32'(irq), 1);
    push(1'b0, pat(1023));
    push(1'b0, 8'hEE);   // dropped, queue holds 1024
    rdStat();

    // R2 drain in order
    errs = 0;
    for (int k = 0; k < 1024; k++) begin
      pop1();
      if (sampA !== pat(k)) errs++;
    end
    chk("R2 drain order errors", 32'(errs), 0);
    chk("R7 empty after drain", 32'(statData), 32'h3);
    chk("R7 irq on empty", 32'(irq), 1);
    pop1();
    chk("R4 dropped byte absent / R3 mid", 32'(sampA), 32'h80);
    rdStat();

    // R6 disabled half interrupt
    ctl(8'h00);
    for (int k = 0; k < 512; k++) push(1'b1, 8'(k));
    chk("R6 disabled no irq", 32'(irq), 0);

    // R10 flush with a colliding push
    step(1'b1, 1'b0, 8'h77, 1'b1, 8'h83, 1'b0, 1'b0);
    chk("R10 status", 32'(statData), 0);
    chk("R10 irq", 32'(irq), 0);
    pop1();
    chk("R10 A empty", 32'(sampA), 32'h80);
    chk("R10 B empty", 32'(sampB), 32'h80);

    // R8 push and pop together
    for (int k = 0; k < 511; k++) push(1'b0, pat(k));
    rdStat();
    step(1'b1, 1'b0, 8'h99, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 no irq", 32'(irq), 0);
    chk("R8 half refreshed", 32'(statData), 32'h1);
    chk("R8 head byte", 32'(sampA), 32'(pat(0)));

    // R11 idle timer
    ctl(8'h83);
    for (int k = 0; k < 1023; k++) pop1();
    chk("R11 quiet before 1024", 32'(irq), 0);
    pop1();
    chk("R11 irq", 32'(irq), 1);
    chk("R11 all flags", 32'(statData), 32'hF);
    rdStat();
    for (int k = 0; k < 1024; k++) pop1();
    chk("R11 repeat", 32'(statData), 32'hF);

    // R3 empty pops leave state intact
    push(1'b0, 8'h3C);
    pop1();
    chk("R3 next byte after empty", 32'(sampA), 32'h3C);

    // constrained random phase
    void'($urandom(32'd4242));
    for (int n = 0; n < 6000; n++) begin
      logic w, s, c, r, t;
      logic [7:0] cd;
      int tp;
      tp = (n < 3000) ? 15 : 60;
      w = ($urandom % 100) < 70;
      s = $urandom % 2;
      t = ($urandom % 100) < tp;
      r = ($urandom % 100) < 4;
      c = ($urandom % 400) == 0;
      cd = {($urandom % 4 == 0) ? 1'b1 : 1'b0, 5'b0, 2'($urandom)};
      step(w, s, 8'($urandom), c, cd, r, t);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule